// File: doc/BRIEF.md
# Ping-Pong Row Buffer with Sixteen-Lane Readout

This block sits between a bank of column converters and the output pads of an image sensor. As each conversion result appears, it is written into a front row store, addressed by column. When the whole row has been digitized, a transfer strobe copies the front store into a back row store in one clock cycle. The front store is then free to collect the next row. Meanwhile the back store is streamed out over sixteen parallel lanes, one word per lane per clock. Lane p carries columns p, p+16, p+32 and so on, so every lane advances in lockstep.

The timing generator drives a readout gate. The gate is held low during the analog gain and sample-and-hold window at the start of each row. While the gate is low the block emits nothing, and it resumes where it stopped when the gate returns. A valid flag marks each emitted beat, and a line-start flag marks the first beat of a row.

If a new transfer arrives before the previous row has been fully sent, the new row still overwrites the back store, readout restarts from its first beat, and a sticky overrun flag is raised.

The controller has three states:
- IDLE: no row is pending.
- READY: a row is loaded and no beat of it has been sent.
- SEND: some beats of the row have been sent.

Its transitions are:
- Any state to READY on a transfer.
- READY or SEND to SEND when a beat that is not the last is emitted.
- READY or SEND to IDLE when the last beat is emitted.
- Any other state to IDLE.

Top module: `rowbuf_pingpong`

## Requirements
- R1: After reset, out_valid, out_sol and out_overrun are 0, every lane is 0, and the back store holds no row, so raising the gate produces no output.
- R2: A write with wr_en high stores wr_data at front column wr_col. A later transfer copies it into the back store.
- R3: A transfer copies the front contents as they stood before that clock edge. A write in the same cycle lands in the front store only and appears with the following row.
- R4: In beat b, lane p (bits [p*10 +: 10] of out_lanes) carries column b*16+p of the transferred row.
- R5: A row is sent as NCOL/16 beats. Each beat appears with out_valid one cycle after a clock edge at which the gate was high.
- R6: While the gate is low no beat is emitted. When the gate returns, readout resumes with the next unsent beat.
- R7: out_sol is 1 together with beat 0 only.
- R8: out_lanes is all zero whenever out_valid is 0.
- R9: A transfer while the controller is in READY or SEND sets out_overrun, which stays 1 until reset. Readout then restarts at beat 0 with the new contents. A transfer in IDLE leaves out_overrun unchanged.
- R10: In a cycle with a transfer strobe, no beat is emitted.
- R11: A transfer does not clear the front store. Columns that are not rewritten keep their values for the next transfer.
- R12: After its last beat a row is not sent again. The output stays idle until the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Conversion result write enable |
| wr_col | input | $clog2(NCOL) | Column address of the result |
| wr_data | input | DW | Conversion result |
| xfer | input | 1 | End-of-digitization transfer strobe |
| rd_gate | input | 1 | Readout permitted (low during analog sampling) |
| out_lanes | output | LANES*DW | Sixteen lane words, lane p at [p*DW +: DW] |
| out_valid | output | 1 | Lanes carry a beat |
| out_sol | output | 1 | First beat of a row |
| out_overrun | output | 1 | Sticky: transfer arrived before the row was fully sent |

## Verification
Every column of a row is written with a value computed arithmetically from its row and column number. Each beat is compared lane by lane against the expected column mapping, which separates correct lane interleaving from shifted or swapped indices.

Three gate patterns are used: continuous, broken by gaps of several cycles, and a gate that is high during the transfer cycle. Together they distinguish pausing from skipping beats, and they show that the transfer cycle is suppressed. A write that coincides with a transfer, and a repeated transfer without any rewrite, show which row a word belongs to. A transfer in mid-row and a transfer in IDLE separate an overrun from normal operation.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SEND  = 2'd2
    } rd_state_t;
endpackage

// File: rtl/rowbuf_front.sv
module rowbuf_front #(
    parameter int NCOL = 48,
    parameter int DW   = 10,
    parameter int CW   = $clog2(NCOL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CW-1:0]      wr_col,
    input  logic [DW-1:0]      wr_data,
    output logic [NCOL*DW-1:0] row_flat
);
    for (genvar i = 0; i < NCOL; i++) begin : g_col
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (wr_en && (wr_col == CW'(i)))
                cell_q <= wr_data;
        end
        assign row_flat[i*DW +: DW] = cell_q;
    end
endmodule

// File: rtl/rowbuf_back.sv
module rowbuf_back #(
    parameter int NCOL  = 48,
    parameter int DW    = 10,
    parameter int LANES = 16,
    parameter int BW    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [NCOL*DW-1:0]  row_in,
    input  logic                emit,
    input  logic [BW-1:0]       beat,
    output logic [LANES*DW-1:0] lanes_q
);
    logic [NCOL*DW-1:0]  bank_q;
    logic [LANES*DW-1:0] sel;

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (load)
            bank_q <= row_in;
    end

    for (genvar p = 0; p < LANES; p++) begin : g_lane
        always_comb begin
            int idx;
            idx = int'(beat) * LANES + p;
            if (idx < NCOL)
                sel[p*DW +: DW] = bank_q[idx*DW +: DW];
            else
                sel[p*DW +: DW] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lanes_q <= '0;
        else if (emit)
            lanes_q <= sel;
        else
            lanes_q <= '0;
    end

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bank_q == $past(row_in)));

    // R8
    lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !emit |=> (lanes_q == '0));
endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
    import rowbuf_pkg::*;
#(
    parameter int NBEAT = 3,
    parameter int BW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer,
    input  logic          gate,
    output logic          emit,
    output logic [BW-1:0] beat,
    output logic          out_valid,
    output logic          out_sol,
    output logic          out_overrun
);
    localparam logic [BW-1:0] LAST_BEAT = BW'(NBEAT - 1);

    rd_state_t     state_q, state_d;
    logic [BW-1:0] beat_q, beat_d;

    assign beat = beat_q;

    always_comb begin
        emit    = !xfer && gate && (state_q != ST_IDLE);
        state_d = state_q;
        beat_d  = beat_q;
        if (xfer) begin
            state_d = ST_READY;
            beat_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_READY, ST_SEND: begin
                    if (gate) begin
                        if (beat_q == LAST_BEAT) begin
                            state_d = ST_IDLE;
                            beat_d  = '0;
                        end else begin
                            state_d = ST_SEND;
                            beat_d  = beat_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    beat_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sol     <= 1'b0;
            out_overrun <= 1'b0;
        end else begin
            out_valid <= emit;
            out_sol   <= emit && (beat_q == '0);
            if (xfer && (state_q != ST_IDLE))
                out_overrun <= 1'b1;
        end
    end

    // R6
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(gate));

    // R10
    xfer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !out_valid);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_overrun |=> out_overrun);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !xfer) |=> !out_valid);

    // R7
    sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R5
    beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(beat_q) < NBEAT);
endmodule

// File: rtl/rowbuf_pingpong.sv
module rowbuf_pingpong #(
    parameter int NCOL  = 48,
    parameter int DW    = 10,
    parameter int LANES = 16,
    localparam int CW    = $clog2(NCOL),
    localparam int NBEAT = NCOL / LANES,
    localparam int BW    = (NBEAT > 1) ? $clog2(NBEAT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_col,
    input  logic [DW-1:0]       wr_data,
    input  logic                xfer,
    input  logic                rd_gate,
    output logic [LANES*DW-1:0] out_lanes,
    output logic                out_valid,
    output logic                out_sol,
    output logic                out_overrun
);
    logic [NCOL*DW-1:0] front_row;
    logic               emit;
    logic [BW-1:0]      beat;

    rowbuf_front #(.NCOL(NCOL), .DW(DW), .CW(CW)) u_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col),
        .wr_data(wr_data), .row_flat(front_row)
    );

    rowbuf_ctrl #(.NBEAT(NBEAT), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .gate(rd_gate),
        .emit(emit), .beat(beat), .out_valid(out_valid),
        .out_sol(out_sol), .out_overrun(out_overrun)
    );

    rowbuf_back #(.NCOL(NCOL), .DW(DW), .LANES(LANES), .BW(BW)) u_back (
        .clk(clk), .rst_n(rst_n), .load(xfer), .row_in(front_row),
        .emit(emit), .beat(beat), .lanes_q(out_lanes)
    );

    initial begin
        // R4
        lane_div_chk: assert (NCOL % LANES == 0 && NBEAT >= 1);
    end
endmodule

// File: tb/rowbuf_pingpong_test.sv
module rowbuf_pingpong_test;
    localparam int NCOL  = 48;
    localparam int DW    = 10;
    localparam int LANES = 16;
    localparam int CW    = $clog2(NCOL);
    localparam int NBEAT = NCOL / LANES;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [CW-1:0]       wr_col = '0;
    logic [DW-1:0]       wr_data = '0;
    logic                xfer = 1'b0;
    logic                rd_gate = 1'b0;
    logic [LANES*DW-1:0] out_lanes;
    logic                out_valid, out_sol, out_overrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int fr [NCOL];
    int bk [NCOL];

    always #4 clk = ~clk;

    rowbuf_pingpong #(.NCOL(NCOL), .DW(DW), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col),
        .wr_data(wr_data), .xfer(xfer), .rd_gate(rd_gate),
        .out_lanes(out_lanes), .out_valid(out_valid), .out_sol(out_sol),
        .out_overrun(out_overrun)
    );

    function automatic int pix(input int r, input int c);
        return (r * 97 + c * 13 + 5) % 1024;
    endfunction

    function automatic logic [LANES*DW-1:0] exp_beat(input int b);
        logic [LANES*DW-1:0] v;
        for (int p = 0; p < LANES; p++) v[p*DW +: DW] = bk[b*LANES + p][DW-1:0];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [LANES*DW-1:0] act,
                       input logic [LANES*DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic g, input logic x, input logic we, input int col, input int d);
        rd_gate = g; xfer = x; wr_en = we;
        wr_col = col[CW-1:0]; wr_data = d[DW-1:0];
        @(posedge clk); #2;
        if (x) for (int c = 0; c < NCOL; c++) bk[c] = fr[c];
        if (we) fr[col] = d;
        xfer = 1'b0; wr_en = 1'b0;
    endtask

    task automatic quiet(input string tag);
        chk(out_valid == 1'b0, {tag, " valid"}, {159'b0, out_valid}, '0);
        chk(out_sol == 1'b0, {tag, " sol"}, {159'b0, out_sol}, '0);
        chk(out_lanes == '0, {tag, " R8 lanes"}, out_lanes, '0);
    endtask

    task automatic beat_ok(input int b, input string tag);
        chk(out_valid == 1'b1, {tag, " R5 valid"}, {159'b0, out_valid}, 1);
        chk(out_sol == (b == 0), {tag, " R7 sol"}, {159'b0, out_sol}, {159'b0, (b == 0)});
        chk(out_lanes == exp_beat(b), {tag, " R4 lanes"}, out_lanes, exp_beat(b));
    endtask

    task automatic ovr(input logic e, input string tag);
        chk(out_overrun == e, {tag, " R9 overrun"}, {159'b0, out_overrun}, {159'b0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCOL; c++) begin fr[c] = 0; bk[c] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        quiet("R1 reset");
        ovr(1'b0, "R1 reset");
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, 0, 0);
            quiet("R1 gate without row");
        end

        // R2 row A written column by column
        for (int c = 0; c < NCOL; c++) step(0, 0, 1, c, pix(0, c));
        step(1, 1, 0, 0, 0);
        quiet("R10 transfer cycle");
        ovr(1'b0, "R9 transfer in idle");
        for (int b = 0; b < NBEAT; b++) begin
            step(1, 0, 0, 0, 0);
            beat_ok(b, "R2 row A");
        end
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0, 0, 0);
            quiet("R12 after last beat");
        end

        // row B, transfer with coincident write to column 0
        for (int c = 0; c < NCOL; c++) step(0, 0, 1, c, pix(1, c));
        step(0, 1, 1, 0, 1000);
        quiet("R3 transfer gate low");
        // R6 gated stream: 1,0,0,1,1,1
        step(1, 0, 0, 0, 0); beat_ok(0, "R3 row B old col0");
        step(0, 0, 0, 0, 0); quiet("R6 gate low");
        step(0, 0, 0, 0, 0); quiet("R6 gate low");
        step(1, 0, 0, 0, 0); beat_ok(1, "R6 resume");
        step(1, 0, 0, 0, 0); beat_ok(2, "R6 resume");
        step(1, 0, 0, 0, 0); quiet("R12 row B done");

        // R11 transfer again without rewriting: col0=1000, rest row B
        step(0, 1, 0, 0, 0);
        quiet("R11 transfer");
        for (int b = 0; b < NBEAT; b++) begin
            step(1, 0, 0, 0, 0);
            beat_ok(b, "R11 retained front");
        end
        step(1, 0, 0, 0, 0); quiet("R12 row again done");
        ovr(1'b0, "R9 no overrun yet");

        // R9 overrun in mid-row
        for (int c = 0; c < NCOL; c++) step(0, 0, 1, c, pix(2, c));
        step(1, 1, 0, 0, 0); quiet("R10 transfer C");
        step(1, 0, 0, 0, 0); beat_ok(0, "R9 row C first");
        for (int c = 0; c < NCOL; c += 5) step(0, 0, 1, c, pix(3, c));
        step(1, 1, 0, 0, 0);
        quiet("R10 overrun transfer");
        ovr(1'b1, "R9 mid-row transfer");
        for (int b = 0; b < NBEAT; b++) begin
            step(1, 0, 0, 0, 0);
            beat_ok(b, "R9 restart");
        end
        step(1, 0, 0, 0, 0); quiet("R12 after restart");
        ovr(1'b1, "R9 sticky");
        // transfer in READY also counts
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        ovr(1'b1, "R9 ready transfer");
        for (int b = 0; b < NBEAT; b++) begin
            step(1, 0, 0, 0, 0);
            beat_ok(b, "R9 after ready transfer");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule